// File: doc/BRIEF.md
# Programmable periodic interrupt divider

This block turns a 32.768 kHz timebase into a periodic event. A 4-bit rate code selects a power-of-two period. Events are not counted from the moment the code was written. They fall on the period boundaries of a free-running 15-bit count of timebase ticks. That count advances only on the ticks.

The block runs only when the rate code is nonzero and at least one consumer is enabled. A consumer is either the interrupt path or the square-wave output. Every event pulses a strobe that sets an external periodic flag. When interrupts are enabled, the same event also pulses an interrupt-request strobe. When the square-wave output is enabled, each event gives one single-cycle pulse on it, not a 50% duty wave. All three outputs are registered and appear in the clock cycle after the tick that caused the event.

Top module: `prd_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `flag_set_o`, `irq_o` and `sqw_o` are 0.
- R2: When `rate_i` is 0, no output ever pulses.
- R3: When both `pie_i` and `sqwe_i` are 0, no output ever pulses.
- R4: The tick count N starts at 0 at reset and rises by one on each clock edge with `tick_i` = 1. For a nonzero `rate_i` value c from 3 to 15, the period P is 2^(c-1) ticks, so c = 3 gives P = 4 and c = 15 gives P = 16384. An event occurs for the tick that brings N to a multiple of P.
- R5: The codes 1 and 2 behave exactly like codes 8 and 9, giving periods of 128 and 256 ticks.
- R6: A change of `rate_i` causes no extra event. The first event under the new code falls on the next multiple of the new period in N, not a fixed delay after the change.
- R7: `flag_set_o` pulses for every event. `irq_o` pulses together with it only when `pie_i` = 1.
- R8: `sqw_o` pulses together with `flag_set_o` only when `sqwe_i` = 1. Each pulse lasts one clock cycle.
- R9: N is 15 bits wide and wraps from 32767 to 0. The wrap counts as a multiple of every period, so with code 15 the tick that brings N to 32768 gives an event.
- R10: Outputs pulse only in the cycle directly after a clock edge with `tick_i` = 1. Clock edges without a tick do not advance N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz timebase enable |
| rate_i | input | 4 | Rate code; 0 disables the block |
| pie_i | input | 1 | Periodic interrupt enable |
| sqwe_i | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | Strobe that sets the external periodic flag |
| irq_o | output | 1 | Interrupt request strobe |
| sqw_o | output | 1 | Square-wave pulse |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe sampled on the rising clock edge. They also assume that the rate code and the enables are steady around each sampling edge, because every check relates an input in one cycle to the outputs in the next. The bench changes all inputs only on falling edges and holds them for a full cycle. It never sets `tick_i` in two consecutive cycles when a minimum gap matters, and it only uses rate codes that give periods of at least four ticks. This keeps the stimulus inside what the no-back-to-back-event check expects.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef struct packed {
    logic flag;
    logic irq;
    logic sqw;
  } prd_evt_t;
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
  parameter int CNT_W     = 15,
  parameter int CODE_W    = 4,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_OFS = 7
) (
  input  logic [CODE_W-1:0] rate_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  mask_o
);
  localparam int EFF_W = CODE_W + 1;

  logic [EFF_W-1:0] eff_code;

  always_comb begin
    if (int'(rate_i) <= ALIAS_MAX) eff_code = EFF_W'(int'(rate_i) + ALIAS_OFS);
    else                           eff_code = EFF_W'(rate_i);
  end

  assign run_o = (rate_i != '0);

  // period = 2^(eff-1); mask holds the low eff-1 bits
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (i < int'(eff_code) - 1);
  end
endmodule

// File: rtl/prd_tick_counter.sv
module prd_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/prd_event_gen.sv
module prd_event_gen
  import prd_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             pie_i,
  input  logic             sqwe_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] mask_i,
  output prd_evt_t         evt_o
);
  logic     boundary;
  logic     hit;
  prd_evt_t evt_d;

  assign boundary = ((cnt_nxt_i & mask_i) == '0);
  assign hit      = tick_i & run_i & (pie_i | sqwe_i) & boundary;

  always_comb begin
    evt_d.flag = hit;
    evt_d.irq  = hit & pie_i;
    evt_d.sqw  = hit & sqwe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= evt_d;
  end
endmodule

// File: rtl/prd_divider.sv
module prd_divider
  import prd_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int CODE_W    = 4,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_OFS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_i,
  input  logic              pie_i,
  input  logic              sqwe_i,
  output logic              flag_set_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic             run;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_nxt;
  prd_evt_t         evt;

  prd_rate_decode #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .ALIAS_MAX(ALIAS_MAX), .ALIAS_OFS(ALIAS_OFS)
  ) u_dec (
    .rate_i(rate_i), .run_o(run), .mask_o(mask)
  );

  prd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_nxt_o(cnt_nxt)
  );

  prd_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run),
    .pie_i(pie_i), .sqwe_i(sqwe_i), .cnt_nxt_i(cnt_nxt), .mask_i(mask),
    .evt_o(evt)
  );

  assign flag_set_o = evt.flag;
  assign irq_o      = evt.irq;
  assign sqw_o      = evt.sqw;
endmodule

// File: rtl/prd_divider_chk.sv
module prd_divider_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [CODE_W-1:0] rate_i,
  input logic              pie_i,
  input logic              sqwe_i,
  input logic              flag_set_o,
  input logic              irq_o,
  input logic              sqw_o
);
  a_r2_code0_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |=> !flag_set_o);
  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pie_i && !sqwe_i) |=> !flag_set_o);
  a_r7_irq_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_set_o);
  a_r7_irq_needs_pie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pie_i |=> !irq_o);
  a_r8_sqw_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_o |-> flag_set_o);
  a_r8_sqw_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqwe_i |=> !sqw_o);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_o |=> !sqw_o);
  a_r10_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !flag_set_o);
endmodule

bind prd_divider prd_divider_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rate_i(rate_i),
  .pie_i(pie_i), .sqwe_i(sqwe_i), .flag_set_o(flag_set_o), .irq_o(irq_o),
  .sqw_o(sqw_o)
);

// File: tb/tb_prd_divider.sv
module tb_prd_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate = '0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       flag_set, irq, sqw;

  int errors = 0;
  int checks = 0;
  int ticks  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_i(rate), .pie_i(pie),
    .sqwe_i(sqwe), .flag_set_o(flag_set), .irq_o(irq), .sqw_o(sqw)
  );

  function automatic int period_of(input int code);
    int c;
    c = (code <= 2) ? code + 7 : code;
    return 1 << (c - 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at tick %0d: actual=%0d expected=%0d", req, what, ticks, act, exp);
    end
  endtask

  // one clock: drive at falling edge, check after next falling edge
  task automatic step(input bit tk, input int code, input bit p, input bit s, input string req);
    bit ev;
    tick = tk; rate = 4'(code); pie = p; sqwe = s;
    @(posedge clk);
    if (tk) ticks++;
    ev = tk && code != 0 && (p || s) && (((ticks % 32768) % period_of(code)) == 0);
    @(negedge clk);
    chk(req, "flag_set", int'(flag_set), int'(ev));
    chk(req, "irq", int'(irq), int'(ev && p));
    chk(req, "sqw", int'(sqw), int'(ev && s));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "flag_set", int'(flag_set), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "sqw", int'(sqw), 0);
    rst_n = 1'b1;
    ticks = 0;
    @(negedge clk);
    chk("R1", "flag_set after release", int'(flag_set), 0);
  endtask

  task automatic t_code_zero();
    for (int i = 0; i < 300; i++) step(1'b1, 0, 1'b1, 1'b1, "R2");
  endtask

  task automatic t_no_enable();
    for (int i = 0; i < 300; i++) step(1'b1, 3, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_sweep();
    for (int c = 3; c <= 12; c++)
      for (int i = 0; i < 2 * period_of(c); i++) step(1'b1, c, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_alias();
    for (int c = 1; c <= 2; c++)
      for (int i = 0; i < 3 * period_of(c); i++) step(1'b1, c, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_realign();
    while ((ticks % 64) != 5) step(1'b1, 3, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 200; i++) step(1'b1, 7, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 70; i++) step(1'b1, 4, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_irq_gate();
    for (int i = 0; i < 64; i++) step(1'b1, 3, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 64; i++) step(1'b1, 3, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_sqw_pulse();
    int width = 0;
    int maxw  = 0;
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 3, 1'b0, 1'b1, "R8");
      width = sqw ? width + 1 : 0;
      if (width > maxw) maxw = width;
    end
    chk("R8", "max sqw pulse width", maxw, 1);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 80; i++) step(1'(i % 3 == 0), 3, 1'b1, 1'b1, "R10");
  endtask

  task automatic t_wrap();
    int seen = 0;
    while (ticks < 32760) step(1'b1, 15, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 15, 1'b1, 1'b0, "R9");
      if (flag_set) seen++;
    end
    chk("R9", "events across wrap", seen, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_code_zero();
    t_no_enable();
    t_sweep();
    t_alias();
    t_realign();
    t_irq_gate();
    t_sqw_pulse();
    t_gaps();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at tick %0d: actual=running expected=done", ticks);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule